// File: doc/BRIEF.md
# Monitor channel interrupt controller

This block collects the event flags of a serial monitor channel (received bytes, end of a received packet, transmit acknowledge and transmit abort) and folds them into one level-active interrupt request for a host CPU. A received byte is recognised when the MX bit, sampled once per frame, falls from 1 to 0. Two receive enables qualify the receive-data status: one turns it on, the second picks between reporting every byte and reporting only the first byte of each packet. The second enable also grants the channel logic permission to drive the MR handshake bit. A packet starts with the first falling MX edge after MX has stayed high for at least `IDLE_FRAMES` frames.

The host sees a small register port. Address 0 holds the sticky status bits, which clear when read. Address 1 holds the control enables. Address 2 holds the mask. The interrupt line is registered. A write of all ones to the mask drops the line, and writing the previous mask back raises it again if a source is still pending. This gives an edge-triggered interrupt controller a fresh edge. In the alternate mode every received byte sets a separate aggregate bit straight away, and the receive enables are bypassed.

Top module: `mon_irq_ctrl`

## Requirements
- R1: With control bit 0 (receive enable) at 0 and the alternate mode off, status bit 0 (receive data) is never set, not even for the first byte of a packet.
- R2: With control bit 0 at 1 and control bit 1 (MR control) at 0, status bit 0 is set only for a byte whose falling MX edge follows at least IDLE_FRAMES consecutive strobes with MX high.
- R3: With control bits 0 and 1 both at 1, every byte (a strobe with MX 0 whose previous strobe had MX 1) sets status bit 0 and pulses rx_store_o in the same cycle.
- R4: mr_ctrl_en_o equals control bit 1 while alt_mode_i is 0, and is 0 while alt_mode_i is 1.
- R5: Status bit 2 (transmit ack) and status bit 3 (transmit abort) are set only while control bit 2 (transmit enable) is 1. Status bit 1 (end of reception) is set only while control bit 0 is 1.
- R6: Status bits are sticky. A read of address 0 returns the value before the clear and clears the bits at that clock edge. An event in the read cycle stays set.
- R7: irq_o is registered and equals the OR of the status bits ANDed with the inverted mask bits, updated at the same clock edge as the status and mask.
- R8: After a write of 8'hFF to the mask (address 2), irq_o is low. Writing the old mask back raises irq_o if an unmasked bit is pending.
- R9: With alt_mode_i at 1, every byte sets status bit 4 whatever the control bits are, and status bits 0 and 1 are not set.
- R10: After reset, status, control and mask are 0 and irq_o is low. Control reads back in bits 2:0. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alt_mode_i | input | 1 | Alternate mode: direct per-byte aggregate status |
| rx_strobe_i | input | 1 | One pulse per frame; MX sample is valid |
| rx_mx_i | input | 1 | Sampled MX bit |
| rx_end_i | input | 1 | End-of-reception event |
| tx_ack_i | input | 1 | Transmit data acknowledged event |
| tx_abort_i | input | 1 | Transmit abort event |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data (combinational) |
| irq_o | output | 1 | Level interrupt request |
| mr_ctrl_en_o | output | 1 | Permission to drive the MR handshake bit |
| rx_store_o | output | 1 | Pulse: current byte is to be stored |

## Verification
The bench uses the default IDLE_FRAMES of 2, so an idle gap is only two frames long. Random MX streams therefore produce many packet starts, and many bytes inside packets that must not report in first-byte mode. The 8-bit register width keeps every mask pattern reachable, including all ones and the restore. Random read strobes often coincide with events, which exercises the clear-versus-set race.

// File: rtl/mon_irq_pkg.sv
package mon_irq_pkg;
  localparam int REG_W  = 8;
  localparam int CTRL_W = 3;
  // status bit positions
  localparam int ST_RXD = 0;
  localparam int ST_RXE = 1;
  localparam int ST_XAK = 2;
  localparam int ST_XAB = 3;
  localparam int ST_ALT = 4;
  // control bit positions
  localparam int CT_RXEN = 0;
  localparam int CT_MRC  = 1;
  localparam int CT_TXEN = 2;
  // register addresses
  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_MASK = 2'd2;
endpackage

// File: rtl/mon_rx_detect.sv
module mon_rx_detect #(
  parameter int IDLE_FRAMES = 2,
  localparam int CNT_W = $clog2(IDLE_FRAMES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic mx_i,
  output logic byte_o,
  output logic first_o
);
  logic             prev_q;
  logic [CNT_W-1:0] idle_q;

  assign byte_o  = strobe_i && prev_q && !mx_i;
  assign first_o = byte_o && (int'(idle_q) >= IDLE_FRAMES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      idle_q <= '0;
    end else if (strobe_i) begin
      prev_q <= mx_i;
      if (!mx_i)                             idle_q <= '0;
      else if (int'(idle_q) < IDLE_FRAMES)   idle_q <= idle_q + 1'b1;
    end
  end

  // R2: a packet start cannot be followed at once by another
  a_r2_no_back_to_back_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_o |=> !first_o);
endmodule

// File: rtl/mon_irq_regs.sv
module mon_irq_regs
  import mon_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_W-1:0]  set_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [1:0]        addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              irq_o
);
  logic [REG_W-1:0]  stat_q, stat_d, mask_q, mask_d;
  logic [CTRL_W-1:0] ctrl_q;
  logic              irq_q, rd_stat;

  assign rd_stat = rd_i && (addr_i == A_STAT);
  assign mask_d  = (wr_i && addr_i == A_MASK) ? wdata_i : mask_q;

  for (genvar i = 0; i < REG_W; i++) begin : g_stat
    assign stat_d[i] = (rd_stat ? 1'b0 : stat_q[i]) | set_i[i];
    // R6: sticky until read; event in read cycle survives
    a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_q[i] && !rd_stat) |=> stat_q[i]);
    a_r6_race: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_stat && set_i[i]) |=> stat_q[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= '0;
      ctrl_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      mask_q <= mask_d;
      irq_q  <= |(stat_d & ~mask_d);
      if (wr_i && addr_i == A_CTRL) ctrl_q <= wdata_i[CTRL_W-1:0];
    end
  end

  always_comb begin
    unique case (addr_i)
      A_STAT:  rdata_o = stat_q;
      A_CTRL:  rdata_o = {{(REG_W-CTRL_W){1'b0}}, ctrl_q};
      A_MASK:  rdata_o = mask_q;
      default: rdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign irq_o  = irq_q;

  // R8: full mask keeps the line low
  a_r8_full_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '1) |-> !irq_o);
  // R1: receive data bit cannot newly rise while receive enable is off
  a_r1_rx_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q[CT_RXEN] && !stat_q[ST_RXD]) |=> !stat_q[ST_RXD]);
  // R5: transmit bits cannot newly rise while transmit enable is off
  a_r5_tx_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q[CT_TXEN] && !stat_q[ST_XAK] && !stat_q[ST_XAB])
      |=> !(stat_q[ST_XAK] || stat_q[ST_XAB]));
endmodule

// File: rtl/mon_irq_ctrl.sv
module mon_irq_ctrl
  import mon_irq_pkg::*;
#(
  parameter int IDLE_FRAMES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alt_mode_i,
  input  logic             rx_strobe_i,
  input  logic             rx_mx_i,
  input  logic             rx_end_i,
  input  logic             tx_ack_i,
  input  logic             tx_abort_i,
  input  logic             reg_wr_i,
  input  logic             reg_rd_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             irq_o,
  output logic             mr_ctrl_en_o,
  output logic             rx_store_o
);
  logic              byte_ev, first_ev, rx_en, mrc, tx_en;
  logic [CTRL_W-1:0] ctrl;
  logic [REG_W-1:0]  set;

  mon_rx_detect #(.IDLE_FRAMES(IDLE_FRAMES)) u_detect (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (rx_strobe_i),
    .mx_i     (rx_mx_i),
    .byte_o   (byte_ev),
    .first_o  (first_ev)
  );

  assign rx_en = ctrl[CT_RXEN] && !alt_mode_i;
  assign mrc   = ctrl[CT_MRC]  && !alt_mode_i;
  assign tx_en = ctrl[CT_TXEN];

  always_comb begin
    set         = '0;
    set[ST_RXD] = rx_en && byte_ev && (mrc || first_ev);
    set[ST_RXE] = rx_en && rx_end_i;
    set[ST_XAK] = tx_en && tx_ack_i;
    set[ST_XAB] = tx_en && tx_abort_i;
    set[ST_ALT] = alt_mode_i && byte_ev;
  end

  assign mr_ctrl_en_o = mrc;
  assign rx_store_o   = rx_en && mrc && byte_ev;

  mon_irq_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set),
    .wr_i    (reg_wr_i),
    .rd_i    (reg_rd_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .ctrl_o  (ctrl),
    .irq_o   (irq_o)
  );

  // R4: handshake permission never granted in alternate mode
  a_r4_mr_alt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mr_ctrl_en_o |-> !alt_mode_i);
  // R3: storing a byte only happens on a falling MX strobe
  a_r3_store_on_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_store_o |-> (rx_strobe_i && !rx_mx_i));
endmodule

// File: tb/mon_irq_ctrl_test.sv
module mon_irq_ctrl_test;
  localparam int IDLE = 2;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       alt = 0, stb = 0, mx = 1, rend = 0, ack = 0, ab = 0;
  logic       wr = 0, rd = 0;
  logic [1:0] addr = 0;
  logic [7:0] wd = 0, rdata;
  logic       irq, mr_en, store;

  int total = 0, bad = 0;
  bit done = 0;

  // bench model
  logic       m_prev = 1;
  int         m_cnt = 0;
  logic [2:0] m_ctrl = 0;
  logic [7:0] m_mask = 0, m_stat = 0;

  always #4 clk = ~clk;

  mon_irq_ctrl #(.IDLE_FRAMES(IDLE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .alt_mode_i(alt), .rx_strobe_i(stb), .rx_mx_i(mx),
    .rx_end_i(rend), .tx_ack_i(ack), .tx_abort_i(ab), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_addr_i(addr), .reg_wdata_i(wd), .reg_rdata_o(rdata), .irq_o(irq),
    .mr_ctrl_en_o(mr_en), .rx_store_o(store));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_set(logic byte_ev, logic first_ev, logic e, logic a, logic b);
    logic [7:0] s = 8'h00;
    logic rxen = m_ctrl[0] && !alt;
    logic mrc  = m_ctrl[1] && !alt;
    s[0] = rxen && byte_ev && (mrc || first_ev);
    s[1] = rxen && e;
    s[2] = m_ctrl[2] && a;
    s[3] = m_ctrl[2] && b;
    s[4] = alt && byte_ev;
    return s;
  endfunction

  function automatic logic [7:0] exp_read(logic [1:0] a);
    case (a)
      2'd0: return m_stat;
      2'd1: return {5'b0, m_ctrl};
      2'd2: return m_mask;
      default: return 8'h00;
    endcase
  endfunction

  // one cycle: drive after negedge, check comb outputs, clock, check irq
  task automatic step(input logic s_stb, s_mx, s_end, s_ack, s_ab, s_wr, s_rd,
                      input logic [1:0] s_addr, input logic [7:0] s_wd);
    logic bev, fev;
    logic [7:0] st;
    stb = s_stb; mx = s_mx; rend = s_end; ack = s_ack; ab = s_ab;
    wr = s_wr; rd = s_rd; addr = s_addr; wd = s_wd;
    #1;
    bev = s_stb && m_prev && !s_mx;
    fev = bev && (m_cnt >= IDLE);
    st  = exp_set(bev, fev, s_end, s_ack, s_ab);
    if (s_rd) chk(rdata == exp_read(s_addr), "R6 read value", rdata, exp_read(s_addr));
    chk(store == (m_ctrl[0] && m_ctrl[1] && !alt && bev), "R3 rx_store_o", store,
        m_ctrl[0] && m_ctrl[1] && !alt && bev);
    chk(mr_en == (m_ctrl[1] && !alt), "R4 mr_ctrl_en_o", mr_en, m_ctrl[1] && !alt);
    @(posedge clk);
    if (s_stb) begin
      m_prev = s_mx;
      m_cnt  = s_mx ? ((m_cnt < IDLE) ? m_cnt + 1 : IDLE) : 0;
    end
    m_stat = ((s_rd && s_addr == 2'd0) ? 8'h00 : m_stat) | st;
    if (s_wr && s_addr == 2'd1) m_ctrl = s_wd[2:0];
    if (s_wr && s_addr == 2'd2) m_mask = s_wd;
    @(negedge clk);
    chk(irq == |(m_stat & ~m_mask), "R7 irq level", irq, |(m_stat & ~m_mask));
    stb = 0; rend = 0; ack = 0; ab = 0; wr = 0; rd = 0;
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    step(0, mx, 0, 0, 0, 1, 0, a, d);
  endtask
  task automatic rreg(input logic [1:0] a);
    step(0, mx, 0, 0, 0, 0, 1, a, 8'h00);
  endtask
  task automatic frame(input logic b);
    step(1, b, 0, 0, 0, 0, 0, 2'd0, 8'h00);
  endtask

  initial begin
    #(8 * 200000);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(irq == 0, "R10 irq after reset", irq, 0);
    addr = 2'd0; #1 chk(rdata == 0, "R10 status reset", rdata, 0);
    addr = 2'd1; #1 chk(rdata == 0, "R10 ctrl reset", rdata, 0);
    addr = 2'd2; #1 chk(rdata == 0, "R10 mask reset", rdata, 0);
    @(negedge clk);
    rreg(2'd3);

    // R1: receive disabled, a valid packet start sets nothing
    frame(1); frame(1); frame(0);
    chk(m_stat == 0 && irq == 0, "R1 no rx status when disabled", irq, 0);
    rreg(2'd0);

    // R2: first byte only
    wreg(2'd1, 8'h01);
    frame(1); frame(1); frame(0);
    chk(irq == 1, "R2 first byte reported", irq, 1);
    rreg(2'd0);
    frame(1); frame(0); frame(1); frame(0);
    chk(irq == 0, "R2 later bytes not reported", irq, 0);

    // R3: every byte, stored
    wreg(2'd1, 8'h03);
    frame(1); stb = 1; mx = 0; #1;
    chk(store == 1, "R3 store pulse", store, 1);
    @(negedge clk); stb = 0; m_prev = 0; m_cnt = 0;
    m_stat = m_stat | 8'h01;
    chk(irq == 1, "R3 every byte reported", irq, 1);
    rreg(2'd0);

    // R5: transmit gating
    step(0, 1, 0, 1, 1, 0, 0, 2'd0, 0);
    chk(irq == 0, "R5 tx disabled", irq, 0);
    wreg(2'd1, 8'h04);
    step(0, 1, 1, 1, 0, 0, 0, 2'd0, 0);
    chk(m_stat == 8'h04, "R5 ack only, end gated", m_stat, 8'h04);

    // R8: full mask then restore
    wreg(2'd2, 8'hFF);
    chk(irq == 0, "R8 full mask drops irq", irq, 0);
    wreg(2'd2, 8'h00);
    chk(irq == 1, "R8 restore raises irq", irq, 1);

    // R6: event in read cycle survives
    step(0, 1, 0, 0, 1, 0, 1, 2'd0, 0);
    chk(m_stat == 8'h08 && irq == 1, "R6 race event kept", irq, 1);
    rreg(2'd0);

    // R9: alternate mode
    alt = 1; wreg(2'd1, 8'h03);
    frame(1); frame(0);
    chk(m_stat == 8'h10 && irq == 1, "R9 alt byte sets aggregate", irq, 1);
    rreg(2'd0);
    alt = 0;

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r = $urandom;
      if (r[31:28] == 0) alt = r[27];
      if (r[3:0] == 0)      wreg(2'd1, 8'(r[10:8]));
      else if (r[3:0] == 1) wreg(2'd2, (r[11]) ? 8'hFF : 8'(r[19:12]));
      else step(r[4], r[5] | r[6], r[7] & r[8], r[9] & r[10], r[11] & r[12] & r[13],
                0, r[14] & r[15], r[17:16], 8'h00);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule